// File: doc/BRIEF.md
# Clock Scaler and Source Switch

This block builds a core clock from two free-running inputs: a reference oscillator clock and a VCO clock coming from an external PLL model. The reference clock passes through a power-of-two prescaler. The VCO clock passes through a power-of-two postscaler that always adds one more divide-by-2. A glitch-free switch chooses which of the two divider outputs drives the core clock. A toggle stage on the core clock produces a bus clock at half the core rate.

Software reaches the block through two 16-bit registers, both written in the oscillator clock domain. The control word asks for a source. The divide word holds both divider ratios, plus a multiplier field and a lock-loss timing field that are handed on unchanged to the PLL model. A two-bit status code gives the source actually driving the core clock. While the handover between the two clock domains is still running, the code reads as a distinct synchronizing value.

Top module: `clk_scaler_switch`

## Requirements
- R1: After reset the status code is 01, the control readback is 0x0001, the divide readback is 0x0000, and the core clock runs at the oscillator period.
- R2: With the prescaler selected, divide-word bits 9:8 set the core period to the oscillator period times 1, 2, 4 or 8, for codes 00, 01, 10 and 11.
- R3: With the postscaler selected, divide-word bits 11:10 set the core period to the VCO period times 2, 4, 8 or 16, for codes 00, 01, 10 and 11.
- R4: Control bits 1:0 request the source: 01 asks for the prescaler and 10 asks for the postscaler. A control write with 00 or 11 in those bits leaves the request unchanged. The control readback is the current request in bits 1:0, with zeros above.
- R5: The status code reads 01 while the prescaler output drives the core clock and 10 while the postscaler output drives it. While a handover is in progress it reads 00 (11 is also allowed). It settles to the requested code once the handover completes.
- R6: The divide-word readback returns the last written value with bit 7 forced to 0. Bits 6:0 appear on pll_mult_o and bits 15:12 appear on pll_lock_win_o.
- R7: The bus clock period is twice the core clock period.
- R8: No high or low phase of the core clock is ever shorter than the shortest phase of the two divider outputs. This holds across source switches and ratio changes.
- R9: A divider takes on a new ratio only at its terminal count. Its counter never leaves the range of the current ratio.
- R10: The two switch enables are never high together. The old source is gated off before the new source is gated on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| osc_clk_i | input | 1 | Reference oscillator clock; also the register clock |
| vco_clk_i | input | 1 | VCO clock from the PLL model |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 1 | Write target: 0 control word, 1 divide word |
| wr_data_i | input | 16 | Write data |
| ctrl_o | output | 16 | Control readback |
| div_o | output | 16 | Divide-word readback |
| src_status_o | output | 2 | Source-in-use code (01 pre, 10 post, 00/11 synchronizing) |
| pll_mult_o | output | 7 | Multiplier field for the PLL model |
| pll_lock_win_o | output | 4 | Lock-loss timing field for the PLL model |
| core_clk_o | output | 1 | Core clock |
| bus_clk_o | output | 1 | Bus clock, half the core rate |

## Verification
The assertions take for granted that both input clocks run throughout, including during a handover. The postscaler ratio field crosses into the VCO domain bit by bit, so a new divide-word value is assumed to stay put for several VCO cycles before it is used. The stimulus keeps writes at least thirty oscillator cycles apart. It waits until the status code has settled before it requests another source. It measures clock periods only after that settling time.

// File: rtl/cs_pkg.sv
package cs_pkg;
  localparam int unsigned REG_W     = 16;
  localparam int unsigned RATIO_F_W = 2;
  localparam int unsigned MULT_W    = 7;
  localparam int unsigned LOCK_W    = 4;
  localparam int unsigned PRE_LSB   = 8;
  localparam int unsigned POST_LSB  = 10;
  localparam int unsigned LOCK_LSB  = 12;
  localparam logic [REG_W-1:0] DIV_MASK = 16'hFF7F;

  typedef enum logic [1:0] {
    SRC_SYNC_LO = 2'b00,
    SRC_PRE     = 2'b01,
    SRC_POST    = 2'b10,
    SRC_SYNC_HI = 2'b11
  } src_e;
endpackage

// File: rtl/cs_sync.sv
module cs_sync #(
  parameter int unsigned W       = 1,
  parameter int unsigned STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     stg_q[s] <= RST_VAL;
      else if (s == 0) stg_q[s] <= d_i;
      else             stg_q[s] <= stg_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/cs_pow2_div.sv
module cs_pow2_div #(
  parameter int unsigned EXP_W   = 3,
  parameter logic [EXP_W-1:0] RST_EXP = '0,
  localparam int unsigned CNT_W  = (1 << EXP_W) - 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [EXP_W-1:0] exp_i,
  output logic             clk_o
);
  logic [EXP_W-1:0] exp_q;
  logic [CNT_W-1:0] cnt_q, cnt_nxt;
  logic [CNT_W:0]   ratio;
  logic             tc, q_q;

  assign ratio   = (CNT_W+1)'(1) << exp_q;
  assign tc      = ({1'b0, cnt_q} == ratio - 1'b1);
  assign cnt_nxt = cnt_q + 1'b1;

  // new ratio only at terminal count; each period starts high
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      exp_q <= RST_EXP;
      cnt_q <= '0;
      q_q   <= 1'b1;
    end else if (tc) begin
      exp_q <= exp_i;
      cnt_q <= '0;
      q_q   <= 1'b1;
    end else begin
      cnt_q <= cnt_nxt;
      q_q   <= ({1'b0, cnt_nxt} < (ratio >> 1));
    end
  end

  always_comb begin
    if (exp_q == '0) clk_o = clk_i;
    else             clk_o = q_q;
  end

  AST_CNT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ({1'b0, cnt_q} < ratio)); // R9
  AST_RATIO_AT_TC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(exp_q) |-> $past(tc)); // R9
endmodule

// File: rtl/cs_clk_switch.sv
module cs_clk_switch (
  input  logic clk_a_i,
  input  logic clk_b_i,
  input  logic rst_ni,
  input  logic sel_b_i,
  output logic clk_o,
  output logic en_a_o,
  output logic en_b_o
);
  logic a1_q, a2_q, en_a_q;
  logic b1_q, b2_q, en_b_q;

  // leg a (reset owner)
  always_ff @(posedge clk_a_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a1_q <= 1'b1;
      a2_q <= 1'b1;
    end else begin
      a1_q <= ~sel_b_i & ~en_b_q;
      a2_q <= a1_q;
    end
  end
  always_ff @(negedge clk_a_i or negedge rst_ni) begin
    if (!rst_ni) en_a_q <= 1'b1;
    else         en_a_q <= a2_q;
  end

  // leg b
  always_ff @(posedge clk_b_i or negedge rst_ni) begin
    if (!rst_ni) begin
      b1_q <= 1'b0;
      b2_q <= 1'b0;
    end else begin
      b1_q <= sel_b_i & ~en_a_q;
      b2_q <= b1_q;
    end
  end
  always_ff @(negedge clk_b_i or negedge rst_ni) begin
    if (!rst_ni) en_b_q <= 1'b0;
    else         en_b_q <= b2_q;
  end

  assign clk_o  = (clk_a_i & en_a_q) | (clk_b_i & en_b_q);
  assign en_a_o = en_a_q;
  assign en_b_o = en_b_q;

  always_comb begin
    if (rst_ni) begin
      AST_ONE_SRC: assert (!(en_a_q && en_b_q)); // R10
    end
  end
  AST_B_WAITS_A: assert property (@(posedge clk_b_i) disable iff (!rst_ni)
    $rose(b1_q) |-> !$past(en_a_q)); // R10
endmodule

// File: rtl/clk_scaler_switch.sv
module clk_scaler_switch
  import cs_pkg::*;
#(
  parameter int unsigned EXP_W       = 3,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              osc_clk_i,
  input  logic              vco_clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              wr_sel_i,
  input  logic [REG_W-1:0]  wr_data_i,
  output logic [REG_W-1:0]  ctrl_o,
  output logic [REG_W-1:0]  div_o,
  output logic [1:0]        src_status_o,
  output logic [MULT_W-1:0] pll_mult_o,
  output logic [LOCK_W-1:0] pll_lock_win_o,
  output logic              core_clk_o,
  output logic              bus_clk_o
);
  localparam logic [EXP_W-1:0] POST_RST_EXP = EXP_W'(1);

  logic [1:0]       req_q;
  logic [REG_W-1:0] div_q;
  logic             req_ok;
  logic [EXP_W-1:0] pre_exp, post_exp, post_exp_vco;
  logic             pre_clk, post_clk, en_a, en_b;
  logic [1:0]       in_use;
  logic             bus_q;

  assign req_ok = (wr_data_i[1:0] == SRC_PRE) || (wr_data_i[1:0] == SRC_POST);

  always_ff @(posedge osc_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q <= SRC_PRE;
      div_q <= '0;
    end else if (wr_en_i) begin
      if (!wr_sel_i && req_ok) req_q <= wr_data_i[1:0];
      if (wr_sel_i)            div_q <= wr_data_i & DIV_MASK;
    end
  end

  assign pre_exp  = EXP_W'(div_q[PRE_LSB +: RATIO_F_W]);
  assign post_exp = EXP_W'(div_q[POST_LSB +: RATIO_F_W]) + 1'b1;

  cs_sync #(.W(EXP_W), .STAGES(SYNC_STAGES), .RST_VAL(POST_RST_EXP)) u_post_sync (
    .clk_i (vco_clk_i),
    .rst_ni(rst_ni),
    .d_i   (post_exp),
    .q_o   (post_exp_vco)
  );

  cs_pow2_div #(.EXP_W(EXP_W), .RST_EXP('0)) u_pre_div (
    .clk_i (osc_clk_i),
    .rst_ni(rst_ni),
    .exp_i (pre_exp),
    .clk_o (pre_clk)
  );

  cs_pow2_div #(.EXP_W(EXP_W), .RST_EXP(POST_RST_EXP)) u_post_div (
    .clk_i (vco_clk_i),
    .rst_ni(rst_ni),
    .exp_i (post_exp_vco),
    .clk_o (post_clk)
  );

  cs_clk_switch u_switch (
    .clk_a_i(pre_clk),
    .clk_b_i(post_clk),
    .rst_ni (rst_ni),
    .sel_b_i(req_q[1]),
    .clk_o  (core_clk_o),
    .en_a_o (en_a),
    .en_b_o (en_b)
  );

  cs_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b01)) u_stat_sync (
    .clk_i (osc_clk_i),
    .rst_ni(rst_ni),
    .d_i   ({en_b, en_a}),
    .q_o   (in_use)
  );

  // handover shows as 00 until the enable in use matches the request
  assign src_status_o = (in_use == req_q) ? req_q : SRC_SYNC_LO;

  always_ff @(posedge core_clk_o or negedge rst_ni) begin
    if (!rst_ni) bus_q <= 1'b0;
    else         bus_q <= ~bus_q;
  end
  assign bus_clk_o = bus_q;

  assign ctrl_o         = {{(REG_W-2){1'b0}}, req_q};
  assign div_o          = div_q;
  assign pll_mult_o     = div_q[MULT_W-1:0];
  assign pll_lock_win_o = div_q[LOCK_LSB +: LOCK_W];

  AST_REQ_VALID: assert property (@(posedge osc_clk_i) disable iff (!rst_ni)
    $countones(req_q) == 1); // R4
  AST_DIV_WRITE: assert property (@(posedge osc_clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_sel_i) |=> (div_o[MULT_W-1:0] == $past(wr_data_i[MULT_W-1:0]))); // R6
endmodule

// File: tb/clk_scaler_switch_tb.sv
`timescale 1ns/100ps
module clk_scaler_switch_tb;
  localparam real OSC_P = 8.0;
  localparam real VCO_P = 3.0;

  logic osc = 0, vco = 0, rst_n = 0;
  logic wr_en = 0, wr_sel = 0;
  logic [15:0] wr_data = '0;
  logic [15:0] ctrl_o, div_o;
  logic [1:0]  stat;
  logic [6:0]  mult;
  logic [3:0]  lockw;
  logic core, bus;

  int errors = 0, checks = 0, runts = 0;
  bit armed = 0, saw_sync = 0, done = 0;
  real last_t = -1.0;
  logic [1:0]  m_req = 2'b01;
  logic [15:0] m_div = '0;

  always #(OSC_P/2) osc = ~osc;
  always #(VCO_P/2) vco = ~vco;

  clk_scaler_switch u_dut (
    .osc_clk_i(osc), .vco_clk_i(vco), .rst_ni(rst_n),
    .wr_en_i(wr_en), .wr_sel_i(wr_sel), .wr_data_i(wr_data),
    .ctrl_o(ctrl_o), .div_o(div_o), .src_status_o(stat),
    .pll_mult_o(mult), .pll_lock_win_o(lockw),
    .core_clk_o(core), .bus_clk_o(bus)
  );

  task automatic chk_int(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic chk_real(string req, real act, real exp);
    checks++;
    if (act - exp > 0.05 || exp - act > 0.05) begin
      errors++;
      $display("FAIL %s actual=%0.2f expected=%0.2f", req, act, exp);
    end
  endtask

  // reference model, updated at the write edge
  always @(posedge osc) begin
    if (rst_n && wr_en) begin
      if (!wr_sel && (wr_data[1:0] == 2'b01 || wr_data[1:0] == 2'b10)) m_req = wr_data[1:0];
      if (wr_sel) m_div = wr_data & 16'hFF7F;
    end
  end

  // cycle compare away from the active edge
  always @(negedge osc) begin
    if (rst_n && !done) begin
      chk_int("R4", ctrl_o, {14'b0, m_req});
      chk_int("R6", div_o, m_div);
      chk_int("R6", {lockw, mult}, {m_div[15:12], m_div[6:0]});
      checks++;
      if (!(stat == m_req || stat == 2'b00 || stat == 2'b11)) begin
        errors++;
        $display("FAIL R5 actual=0x%0h expected=0x%0h or sync", stat, m_req);
      end
      if (stat == 2'b00) saw_sync = 1;
    end
  end

  // runt monitor on the core clock
  always @(core) begin
    if (armed && last_t >= 0.0 && ($realtime - last_t) < 2.9) runts++;
    last_t = $realtime;
  end

  task automatic wr(input logic sel, input logic [15:0] d);
    @(negedge osc);
    wr_en = 1; wr_sel = sel; wr_data = d;
    @(negedge osc);
    wr_en = 0;
    repeat (30) @(negedge osc);
  endtask

  task automatic period_core(output real p);
    real t0;
    @(posedge core); t0 = $realtime;
    repeat (4) @(posedge core);
    p = ($realtime - t0) / 4.0;
  endtask

  task automatic period_bus(output real p);
    real t0;
    @(posedge bus); t0 = $realtime;
    repeat (2) @(posedge bus);
    p = ($realtime - t0) / 2.0;
  endtask

  task automatic wait_src(input logic [1:0] exp);
    int n = 0;
    while (stat != exp && n < 400) begin @(negedge osc); n++; end
    chk_int("R5", stat, exp);
    repeat (10) @(negedge osc);
  endtask

  initial begin
    #(200000 * OSC_P);
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    real p, pb;
    repeat (3) @(negedge osc);
    rst_n = 1;
    armed = 1;
    @(negedge osc);
    // R1 reset state
    chk_int("R1", stat, 2'b01);
    chk_int("R1", ctrl_o, 16'h0001);
    chk_int("R1", div_o, 16'h0000);
    period_core(p); chk_real("R1", p, OSC_P);
    period_bus(pb); chk_real("R7", pb, 2.0 * OSC_P);

    // R2 prescaler ratios
    for (int k = 1; k < 4; k++) begin
      wr(1'b1, 16'(k) << 8);
      period_core(p); chk_real("R2", p, OSC_P * (1 << k));
    end
    period_bus(pb); chk_real("R7", pb, 2.0 * OSC_P * 8);

    // R6 field storage, bit 7 dropped
    wr(1'b1, 16'hF0FF);
    chk_int("R6", div_o, 16'hF07F);
    chk_int("R6", mult, 7'h7F);
    chk_int("R6", lockw, 4'hF);
    period_core(p); chk_real("R2", p, OSC_P);

    // switch to postscaler (R3, R5)
    wr(1'b1, 16'h3005);
    saw_sync = 0;
    wr(1'b0, 16'h0002);
    wait_src(2'b10);
    chk_int("R5", saw_sync, 1);
    period_core(p); chk_real("R3", p, VCO_P * 2.0);
    period_bus(pb); chk_real("R7", pb, VCO_P * 4.0);

    // R9: ratio change while in use
    wr(1'b1, 16'h3805);
    period_core(p); chk_real("R3", p, VCO_P * 8.0);
    wr(1'b1, 16'h3C05);
    period_core(p); chk_real("R3", p, VCO_P * 16.0);

    // R4: invalid request codes ignored
    wr(1'b0, 16'h0003);
    chk_int("R4", ctrl_o, 16'h0002);
    chk_int("R4", stat, 2'b10);
    wr(1'b0, 16'hFFFC);
    chk_int("R4", ctrl_o, 16'h0002);
    period_core(p); chk_real("R4", p, VCO_P * 16.0);

    // back to prescaler /2
    wr(1'b1, 16'h0D00);
    saw_sync = 0;
    wr(1'b0, 16'h0001);
    wait_src(2'b01);
    chk_int("R5", saw_sync, 1);
    period_core(p); chk_real("R2", p, OSC_P * 2.0);
    period_bus(pb); chk_real("R7", pb, OSC_P * 4.0);

    // R8 / R9 / R10: no shortened phase anywhere in the run
    chk_int("R8", runts, 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule